// File: doc/BRIEF.md
# Modulus Up-Counter with Prescaler

This block is a 16-bit up-counter that restarts from a programmable modulus instead of wrapping through zero. The counter advances once per count event. A count event comes either from an 8-bit prescaler that divides an incoming tick by a programmable ratio, or from rising edges on an external clock pin. A two-bit clock-select field chooses the source. When the counter passes its all-ones value it reloads from a modulus latch and raises an interrupt flag. Edges on an external load pin can also force a reload, and each edge direction is enabled on its own.

Software reaches the block through a simple synchronous register bus with a registered read port. The current count is also driven without pause onto a dedicated counter output bus for neighbouring logic. A freeze input stops counting for debug when the matching enable bit is set. Reset clears the mode fields but keeps the prescaler ratio. The counter and the modulus latch keep no reset value and must be loaded by software.

Top module: `modulus_counter`

## Requirements
- R1: With clock select 1x (bits 9:8 = 10 or 11), a count event occurs once every P+1 cycles in which `tick_i` is high, where P is the control field bits 7:0. So 0x00 divides by 1 and 0xFF divides by 256.
- R2: `cnt_o` always equals the counter value, which a read of address 0 also returns.
- R3: A count event with the counter at 0xFFFF loads the modulus latch value into the counter (not zero) and sets the flag, which drives `irq_o` and reads as control bit 15.
- R4: Reset clears the clock select, freeze-enable, both edge-enable bits and the flag, and keeps the prescaler field bits 7:0.
- R5: Control bit 14 reads the synchronized level of `ext_clk_i` and bit 13 reads the synchronized level of `ext_load_i`. Writes to these bits have no effect.
- R6: Clock select 00 stops counting. 01 counts rising edges of `ext_clk_i`. 10 and 11 count prescaler overflows, and pin edges are then ignored.
- R7: A write to address 0 loads both the counter and the modulus latch. A write to address 1 loads only the modulus latch. Address 1 reads back the latch.
- R8: A write to the control register (address 2) restarts the prescaler, so the next overflow comes P+1 ticks after that write.
- R9: With bit 11 set, a rising edge of `ext_load_i` reloads the counter from the modulus latch. With bit 10 set, a falling edge does the same. An edge whose bit is clear has no effect.
- R10: While `freeze_i` is high and freeze-enable (bit 12) is set, the counter holds.
- R11: Writing 0 to bit 15 clears the flag only if a control read has returned bit 15 = 1 since the flag was last cleared. Writing 1, or writing 0 without that read, leaves the flag set.
- R12: When an overflow and an armed clearing write fall in the same cycle, the flag stays set and the arming stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler input enable, one pulse per tick |
| freeze_i | input | 1 | Debug freeze request |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| ext_load_i | input | 1 | External reload pin (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 counter, 1 modulus, 2 control |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| cnt_o | output | 16 | Dedicated counter value bus |
| irq_o | output | 1 | Overflow flag / interrupt request |

## Verification
The counter overflow that sets the flag and the software write that clears it can land on the same clock edge. The bench arms the clear with a control read, then raises `tick_i` on the very cycle the zero-writing control access is presented, with the counter at 0xFFFF. It judges the result by `irq_o` staying high and the counter holding the new modulus value. A following clearing write, with no new read, must then drop the flag, which shows the arming survived.

// File: rtl/modctr_pkg.sv
package modctr_pkg;
  typedef enum logic [1:0] {
    CS_OFF   = 2'b00,
    CS_PIN   = 2'b01,
    CS_PSC_A = 2'b10,
    CS_PSC_B = 2'b11
  } clksel_e;

  localparam logic [1:0] A_COUNT   = 2'd0;
  localparam logic [1:0] A_MODULUS = 2'd1;
  localparam logic [1:0] A_CTRL    = 2'd2;
endpackage

// File: rtl/modctr_sync.sv
module modctr_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    stg_q[0] <= pin_i;
    for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/modctr_prescaler.sv
module modctr_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         ovf_o
);
  logic [W-1:0] pcnt_q;
  logic         hit;

  assign hit   = (pcnt_q == div_i);
  assign ovf_o = tick_i & hit;

  always_ff @(posedge clk) begin
    if (restart_i)   pcnt_q <= '0;
    else if (tick_i) pcnt_q <= hit ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/modctr_core.sv
module modctr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         wr_cnt_i,
  input  logic         wr_mod_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  input  logic         count_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] mod_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] mod_q;
  logic         at_top;

  assign at_top = &cnt_q;
  assign wrap_o = count_i & ~wr_cnt_i & ~load_i & at_top;

  always_ff @(posedge clk) begin
    if (wr_cnt_i || wr_mod_i) mod_q <= wdata_i;
    if (wr_cnt_i)     cnt_q <= wdata_i;
    else if (load_i)  cnt_q <= mod_q;
    else if (count_i) cnt_q <= at_top ? mod_q : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign mod_o = mod_q;
endmodule

// File: rtl/modulus_counter.sv
module modulus_counter
  import modctr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             ext_clk_i,
  input  logic             ext_load_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam int B_CS    = PSC_W;
  localparam int B_FALL  = PSC_W + 2;
  localparam int B_RISE  = PSC_W + 3;
  localparam int B_FRZ   = PSC_W + 4;
  localparam int B_LDPIN = PSC_W + 5;
  localparam int B_CKPIN = PSC_W + 6;
  localparam int B_FLAG  = CNT_W - 1;

  logic [PSC_W-1:0] psc_q;
  clksel_e          cs_q;
  logic             rise_en_q, fall_en_q, frz_en_q;
  logic             flag_q, armed_q;
  logic [CNT_W-1:0] rdata_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] ctrl_view;

  logic [1:0] pin_lvl, pin_rise, pin_fall;
  logic       psc_ovf, count_evt, load_evt, wrap_evt;
  logic       wr_cnt, wr_mod, wr_ctrl, rd_ctrl, clr_req;

  assign wr_cnt  = wr_en_i & (addr_i == A_COUNT);
  assign wr_mod  = wr_en_i & (addr_i == A_MODULUS);
  assign wr_ctrl = wr_en_i & (addr_i == A_CTRL);
  assign rd_ctrl = rd_en_i & (addr_i == A_CTRL);

  modctr_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .pin_i  ({ext_load_i, ext_clk_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  modctr_prescaler #(.W(PSC_W)) u_psc (
    .clk       (clk),
    .restart_i (wr_ctrl),
    .tick_i    (tick_i),
    .div_i     (psc_q),
    .ovf_o     (psc_ovf)
  );

  always_comb begin
    count_evt = 1'b0;
    if (!(freeze_i && frz_en_q)) begin
      case (cs_q)
        CS_PIN:             count_evt = pin_rise[0];
        CS_PSC_A, CS_PSC_B: count_evt = psc_ovf;
        default:            count_evt = 1'b0;
      endcase
    end
  end

  assign load_evt = (rise_en_q & pin_rise[1]) | (fall_en_q & pin_fall[1]);

  modctr_core #(.W(CNT_W)) u_core (
    .clk      (clk),
    .wr_cnt_i (wr_cnt),
    .wr_mod_i (wr_mod),
    .wdata_i  (wdata_i),
    .load_i   (load_evt),
    .count_i  (count_evt),
    .cnt_o    (cnt_o),
    .mod_o    (mod_q),
    .wrap_o   (wrap_evt)
  );

  // prescaler ratio survives reset
  always_ff @(posedge clk) begin
    if (wr_ctrl) psc_q <= wdata_i[PSC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= CS_OFF;
      rise_en_q <= 1'b0;
      fall_en_q <= 1'b0;
      frz_en_q  <= 1'b0;
    end else if (wr_ctrl) begin
      cs_q      <= clksel_e'(wdata_i[B_CS+1:B_CS]);
      rise_en_q <= wdata_i[B_RISE];
      fall_en_q <= wdata_i[B_FALL];
      frz_en_q  <= wdata_i[B_FRZ];
    end
  end

  assign clr_req = wr_ctrl & armed_q & ~wdata_i[B_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wrap_evt)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (clr_req && !wrap_evt)   armed_q <= 1'b0;
      else if (rd_ctrl && flag_q) armed_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_view                   = '0;
    ctrl_view[PSC_W-1:0]        = psc_q;
    ctrl_view[B_CS+1:B_CS]      = cs_q;
    ctrl_view[B_FALL]           = fall_en_q;
    ctrl_view[B_RISE]           = rise_en_q;
    ctrl_view[B_FRZ]            = frz_en_q;
    ctrl_view[B_LDPIN]          = pin_lvl[1];
    ctrl_view[B_CKPIN]          = pin_lvl[0];
    ctrl_view[B_FLAG]           = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en_i) begin
      case (addr_i)
        A_COUNT:   rdata_q <= cnt_o;
        A_MODULUS: rdata_q <= mod_q;
        A_CTRL:    rdata_q <= ctrl_view;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flag_q;
endmodule

// File: rtl/modctr_chk.sv
module modctr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             freeze_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             irq_o,
  input logic [1:0]       cs_q,
  input logic             frz_en_q,
  input logic             rise_en_q,
  input logic             fall_en_q,
  input logic [CNT_W-1:0] mod_q,
  input logic             count_evt,
  input logic             load_evt,
  input logic             wrap_evt
);
  logic wr_cnt_c;
  assign wr_cnt_c = wr_en_i && (addr_i == 2'd0);

  p_cnt_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_c |=> (cnt_o == $past(wdata_i) && mod_q == $past(wdata_i)));

  p_off_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_q == 2'b00 && !load_evt && !wr_cnt_c) |=> $stable(cnt_o));

  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (freeze_i && frz_en_q && !load_evt && !wr_cnt_c) |=> $stable(cnt_o));

  p_wrap_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (count_evt && (&cnt_o) && !load_evt && !wr_cnt_c) |=> (cnt_o == $past(mod_q) && irq_o));

  p_pin_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (load_evt && !wr_cnt_c) |=> (cnt_o == $past(mod_q)));

  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> irq_o);

  p_clear_by_write_r11: assert property (@(posedge clk) disable iff (rst)
    ($fell(irq_o) && !$past(rst)) |-> $past(wr_en_i && addr_i == 2'd2 && !wdata_i[CNT_W-1]));

  p_reset_fields_r4: assert property (@(posedge clk)
    rst |=> (cs_q == 2'b00 && !frz_en_q && !rise_en_q && !fall_en_q && !irq_o));
endmodule

bind modulus_counter modctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .freeze_i  (freeze_i),
  .cnt_o     (cnt_o),
  .irq_o     (irq_o),
  .cs_q      (cs_q),
  .frz_en_q  (frz_en_q),
  .rise_en_q (rise_en_q),
  .fall_en_q (fall_en_q),
  .mod_q     (mod_q),
  .count_evt (count_evt),
  .load_evt  (load_evt),
  .wrap_evt  (wrap_evt)
);

// File: tb/modulus_counter_tb.sv
`timescale 1ns/1ps
module modulus_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b1;
  logic        freeze_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        ext_load_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o, cnt_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  modulus_counter u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .freeze_i(freeze_i),
    .ext_clk_i(ext_clk_i), .ext_load_i(ext_load_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .cnt_o(cnt_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] ctrl(input logic fl, input logic frz, input logic ri,
                                       input logic fa, input logic [1:0] cs, input logic [7:0] p);
    return {fl, 2'b00, frz, ri, fa, cs, p};
  endfunction

  // returns {flag_set, final_value}
  function automatic logic [16:0] model(input logic [15:0] start, input logic [15:0] ml, input int ev);
    logic [15:0] v = start;
    logic        f = 1'b0;
    for (int i = 0; i < ev; i++) begin
      if (v == 16'hFFFF) begin v = ml; f = 1'b1; end
      else v = v + 16'd1;
    end
    return {f, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; rv = rdata_o;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_and_clear();
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b00, 8'h00));
    rd(2'd2);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b00, 8'h00));
  endtask

  task automatic run_psc(input logic [15:0] st, input logic [15:0] ml, input logic [7:0] p,
                         input int n, input string tag);
    logic [16:0] e;
    stop_and_clear();
    wr(2'd0, st);
    wr(2'd1, ml);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b10, p));
    repeat (n) @(posedge clk);
    @(negedge clk);
    e = model(st, ml, n / (int'(p) + 1));
    chk({tag, " count"}, {16'h0, cnt_o}, {16'h0, e[15:0]});
    chk("R3 flag", {31'h0, irq_o}, {31'h0, e[16]});
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    waitn(4);
    rst = 1'b0;
    // R4: reset keeps prescaler field, clears mode bits
    wr(2'd2, ctrl(0, 1, 1, 1, 2'b01, 8'h37));
    @(negedge clk); rst = 1'b1;
    waitn(2); rst = 1'b0;
    rd(2'd2);
    chk("R4 psc kept", {24'h0, rv[7:0]}, 32'h37);
    chk("R4 fields cleared", {27'h0, rv[12:8]}, 32'h0);
    chk("R4 flag cleared", {31'h0, rv[15]}, 32'h0);
    // R6 disabled after reset, R2 bus equals read, R7
    wr(2'd0, 16'h0100);
    waitn(20);
    chk("R6 disabled", {16'h0, cnt_o}, 32'h0100);
    rd(2'd0);
    chk("R2 cnt bus vs read", {16'h0, rv}, {16'h0, cnt_o});
    rd(2'd1);
    chk("R7 counter write fills latch", {16'h0, rv}, 32'h0100);
    wr(2'd1, 16'h0042);
    rd(2'd1);
    chk("R7 latch write", {16'h0, rv}, 32'h0042);
    chk("R7 latch write keeps counter", {16'h0, cnt_o}, 32'h0100);

    // R1 ratios
    run_psc(16'h0100, 16'h0100, 8'h00, 5, "R1 div1");
    run_psc(16'h0000, 16'h0000, 8'hFF, 255, "R1 div256 short");
    run_psc(16'h0000, 16'h0000, 8'hFF, 600, "R1 div256");
    run_psc(16'hFFFE, 16'h0010, 8'h00, 3, "R3 wrap to modulus");
    rd(2'd2);
    chk("R3 flag bit15", {31'h0, rv[15]}, 32'h1);

    // random mix
    for (int it = 0; it < 12; it++) begin
      logic [15:0] st, ml;
      logic [7:0]  p;
      int          n;
      p  = 8'($urandom % 6);
      n  = int'($urandom % 50) + 1;
      st = ($urandom % 2 == 0) ? (16'hFFF0 + 16'($urandom % 16)) : 16'($urandom);
      ml = 16'($urandom);
      run_psc(st, ml, p, n, "R1 random");
    end

    // R8 restart
    stop_and_clear();
    wr(2'd0, 16'h2000);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b10, 8'h03));
    repeat (2) @(posedge clk);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b10, 8'h03));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 restart delays", {16'h0, cnt_o}, 32'h2000);
    @(posedge clk); @(negedge clk);
    chk("R8 overflow after restart", {16'h0, cnt_o}, 32'h2001);

    // R6 pin clock
    stop_and_clear();
    wr(2'd0, 16'h0300);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b01, 8'h00));
    for (int i = 0; i < 3; i++) begin
      ext_clk_i = 1'b1; waitn(4);
      ext_clk_i = 1'b0; waitn(4);
    end
    chk("R6 pin edges counted", {16'h0, cnt_o}, 32'h0303);
    tick_i = 1'b0;
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b10, 8'h00));
    for (int i = 0; i < 2; i++) begin
      ext_clk_i = 1'b1; waitn(4);
      ext_clk_i = 1'b0; waitn(4);
    end
    chk("R6 pin ignored in prescaler mode", {16'h0, cnt_o}, 32'h0303);
    tick_i = 1'b1;

    // R5 pin levels
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b00, 8'h00));
    ext_clk_i = 1'b1; ext_load_i = 1'b0; waitn(4);
    rd(2'd2);
    chk("R5 pin levels 10", {30'h0, rv[14:13]}, 32'h2);
    ext_clk_i = 1'b0; ext_load_i = 1'b1; waitn(4);
    rd(2'd2);
    chk("R5 pin levels 01", {30'h0, rv[14:13]}, 32'h1);
    ext_load_i = 1'b0; waitn(4);
    wr(2'd2, 16'h6000);
    rd(2'd2);
    chk("R5 write ignored", {30'h0, rv[14:13]}, 32'h0);

    // R9 load edges
    wr(2'd2, ctrl(0, 0, 1, 0, 2'b00, 8'h00));
    wr(2'd0, 16'h1111);
    wr(2'd1, 16'h2222);
    ext_load_i = 1'b1; waitn(5);
    chk("R9 rising reload", {16'h0, cnt_o}, 32'h2222);
    wr(2'd0, 16'h3333);
    wr(2'd1, 16'h4444);
    ext_load_i = 1'b0; waitn(5);
    chk("R9 falling ignored", {16'h0, cnt_o}, 32'h3333);
    wr(2'd2, ctrl(0, 0, 0, 1, 2'b00, 8'h00));
    ext_load_i = 1'b1; waitn(5);
    chk("R9 rising ignored", {16'h0, cnt_o}, 32'h3333);
    ext_load_i = 1'b0; waitn(5);
    chk("R9 falling reload", {16'h0, cnt_o}, 32'h4444);

    // R10 freeze
    stop_and_clear();
    wr(2'd0, 16'h0500);
    freeze_i = 1'b1;
    wr(2'd2, ctrl(0, 1, 0, 0, 2'b10, 8'h00));
    waitn(10);
    chk("R10 frozen", {16'h0, cnt_o}, 32'h0500);
    freeze_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 resumes", {16'h0, cnt_o}, 32'h0504);

    // R11 clear handshake
    run_psc(16'hFFFF, 16'h0007, 8'h00, 1, "R3 single wrap");
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b00, 8'h00));
    chk("R11 unarmed write keeps flag", {31'h0, irq_o}, 32'h1);
    rd(2'd2);
    wr(2'd2, ctrl(1, 0, 0, 0, 2'b00, 8'h00));
    chk("R11 write one keeps flag", {31'h0, irq_o}, 32'h1);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b00, 8'h00));
    chk("R11 armed clear", {31'h0, irq_o}, 32'h0);

    // R12 set beats clear
    tick_i = 1'b0;
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b10, 8'h00));
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0AAA);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk("R3 tick wrap", {16'h0, cnt_o}, 32'h0AAA);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0BBB);
    rd(2'd2);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = ctrl(0, 0, 0, 0, 2'b10, 8'h00);
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R12 set wins", {31'h0, irq_o}, 32'h1);
    chk("R12 reload same edge", {16'h0, cnt_o}, 32'h0BBB);
    wr(2'd2, ctrl(0, 0, 0, 0, 2'b10, 8'h00));
    chk("R12 arming kept", {31'h0, irq_o}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule